// File: doc/BRIEF.md
# Scanline Triangle Rasterizer with Gouraud Shading

This block turns one screen-space triangle into a stream of pixel fragments. Each of the three vertices arrives as unsigned integer screen coordinates, a depth value and a precomputed lighting intensity. The block orders the corners by row and walks the triangle one scanline at a time. For each line it emits the two boundary pixels first and then fills the pixels between them. Depth and intensity are interpolated linearly in 16-bit fractional fixed point, so every fragment carries its own z and shade value.

The triangle is split at the middle corner into an upper part and a lower part. The long edge from the first corner to the last serves both parts. The short edge is the first-to-middle edge in the upper part and the middle-to-last edge in the lower part. Slopes are found by one shared serial divider, once per edge and once per scanline. Fragments leave through a valid/ready handshake toward a depth-test stage. A one-cycle completion pulse marks the end of each triangle.

Top module: `scan_tri_raster`

## Requirements
- R1: The corners are sorted by y in ascending order into A, B and C. The sort is stable: corners with equal y keep their input-index order. A triangle whose A and C rows are equal emits no fragment and still raises the completion pulse.
- R2: Fragments are produced for rows yA up to yC-1, in ascending order. Rows below yB use edges AB and AC, and rows from yB on use edges BC and AC. A part of zero height is skipped.
- R3: For an edge P→Q, each value v (x, z, intensity) on row y equals v_P·2^16 + (y−y_P)·s, where s = trunc((v_Q−v_P)·2^16 / (y_Q−y_P)) rounded toward zero. A fragment's integer x is that value shifted right by 16 (floor).
- R4: On each row, the left boundary fragment comes first, then the right boundary fragment, then the interior fragments with x rising one by one. The long edge is the left side when its integer x is less than or equal to the short edge's. When both integer x values are equal, exactly one fragment is produced, and it carries the long edge's z and intensity.
- R5: A boundary fragment carries floor(edge value / 2^16). An interior fragment at x_L+k carries floor((e_L + k·t)/2^16), where t = trunc((e_R − e_L)/(x_R − x_L)) rounded toward zero, and e_L, e_R are the fixed-point edge values. This rule holds separately for depth and for intensity.
- R6: While a fragment is valid and ready is low, valid stays high and x, y, z and intensity hold their values.
- R7: The completion pulse is high for exactly one cycle, after the last fragment of the triangle has been accepted. No fragment is valid in that cycle, and busy is low in the next cycle.
- R8: A start request that arrives while busy is high is ignored. The triangle in progress continues with no change.
- R9: During reset and after it, busy, the fragment valid and the completion pulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the three corners when idle |
| vx | input | 3×8 | Corner x, index 0..2 |
| vy | input | 3×8 | Corner y, index 0..2 |
| vz | input | 3×12 | Corner depth |
| vi | input | 3×8 | Corner intensity |
| busy | output | 1 | A triangle is in progress |
| pix_valid | output | 1 | Fragment present |
| pix_ready | input | 1 | Downstream accepts the fragment |
| pix_x | output | 8 | Fragment x |
| pix_y | output | 8 | Fragment row |
| pix_z | output | 12 | Interpolated depth |
| pix_i | output | 8 | Interpolated intensity |
| done | output | 1 | Triangle finished pulse |

## Verification
The assertions assume the corners are unsigned and that the corners are sampled only on a start that is accepted while idle. Under that assumption, every fragment row falls between the latched A and C rows. The ready input may follow any pattern: the hold check puts no constraint on ready and constrains only what the block does while it is stalled. The stimulus drives start only as a single-cycle pulse, and it changes the corner inputs while busy only to show they have no effect. Ready is randomised at several acceptance rates so that stalls occur on boundary and interior fragments alike.

// File: rtl/tri_pkg.sv
package tri_pkg;
  localparam int XW   = 8;
  localparam int YW   = 8;
  localparam int ZW   = 12;
  localparam int IW   = 8;
  localparam int FRAC = 16;
  localparam int DW   = (XW > YW) ? XW : YW;
  localparam int VW   = (ZW > IW) ? ((ZW > XW) ? ZW : XW) : ((IW > XW) ? IW : XW);
  localparam int ACCW = VW + FRAC + 2;

  typedef struct packed {
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic [ZW-1:0] z;
    logic [IW-1:0] i;
  } vtx_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LDIV, ST_SEG, ST_SDIV, ST_LINE, ST_PDIV, ST_EMIT, ST_FIN
  } st_e;

  typedef enum logic [1:0] { PH_L, PH_R, PH_IN } ph_e;

  // fixed-point form of component k (0 x, 1 z, 2 intensity)
  function automatic logic [ACCW-1:0] fxv(input vtx_t v, input int k);
    logic [VW-1:0] t;
    case (k)
      0:       t = VW'(v.x);
      1:       t = VW'(v.z);
      default: t = VW'(v.i);
    endcase
    return {{(ACCW-VW){1'b0}}, t} << FRAC;
  endfunction
endpackage

// File: rtl/tri_vsort.sv
module tri_vsort
  import tri_pkg::*;
(
  input  vtx_t [2:0] vin,
  output vtx_t [2:0] vout
);
  vtx_t [2:0] s1, s2;

  // three strict compare-exchange steps: stable ordering by y
  always_comb begin
    s1 = vin;
    if (vin[1].y < vin[0].y) begin s1[0] = vin[1]; s1[1] = vin[0]; end
    s2 = s1;
    if (s1[2].y < s1[1].y) begin s2[1] = s1[2]; s2[2] = s1[1]; end
    vout = s2;
    if (s2[1].y < s2[0].y) begin vout[0] = s2[1]; vout[1] = s2[0]; end
  end
endmodule

// File: rtl/tri_sdiv.sv
module tri_sdiv #(
  parameter int NW = 30,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic signed [NW-1:0] num,
  input  logic [DW-1:0]        den,
  output logic                 fin,
  output logic signed [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic          run_q, run_d, neg_q, neg_d, fin_q, fin_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW:0]   rem_q, rem_d, shl;
  logic [NW-1:0] acc_q, acc_d;
  logic [DW-1:0] den_q, den_d;

  always_comb begin
    run_d = run_q; neg_d = neg_q; cnt_d = cnt_q; rem_d = rem_q;
    acc_d = acc_q; den_d = den_q; fin_d = 1'b0;
    shl   = {rem_q[DW-1:0], acc_q[NW-1]};
    if (go) begin
      run_d = 1'b1;
      neg_d = num[NW-1];
      acc_d = num[NW-1] ? NW'(-num) : NW'(num);
      rem_d = '0;
      cnt_d = '0;
      den_d = den;
    end else if (run_q) begin
      if (shl >= {1'b0, den_q}) begin
        rem_d = shl - {1'b0, den_q};
        acc_d = {acc_q[NW-2:0], 1'b1};
      end else begin
        rem_d = shl;
        acc_d = {acc_q[NW-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; neg_q <= 1'b0; fin_q <= 1'b0; cnt_q <= '0;
      rem_q <= '0;   acc_q <= '0;   den_q <= '0;
    end else begin
      run_q <= run_d; neg_q <= neg_d; fin_q <= fin_d; cnt_q <= cnt_d;
      rem_q <= rem_d; acc_q <= acc_d; den_q <= den_d;
    end
  end

  assign fin = fin_q;
  assign quo = neg_q ? -$signed(acc_q) : $signed(acc_q);
endmodule

// File: rtl/scan_tri_raster.sv
module scan_tri_raster
  import tri_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0][XW-1:0]   vx,
  input  logic [2:0][YW-1:0]   vy,
  input  logic [2:0][ZW-1:0]   vz,
  input  logic [2:0][IW-1:0]   vi,
  output logic                 busy,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [XW-1:0]        pix_x,
  output logic [YW-1:0]        pix_y,
  output logic [ZW-1:0]        pix_z,
  output logic [IW-1:0]        pix_i,
  output logic                 done
);
  typedef struct packed {
    st_e                  st;
    logic                 seg;
    logic [1:0]           dq;
    logic                 go;
    vtx_t                 a, b, c;
    logic [2:0][ACCW-1:0] lac, lst, sac, sst;
    logic [YW-1:0]        y, yend;
    logic [XW-1:0]        xl, xr, px;
    logic [1:0][ACCW-1:0] el, er, pst, pac;
    ph_e                  ph;
  } ctx_t;

  logic [1:0] rs_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  vtx_t [2:0] vin, vsrt;
  for (genvar k = 0; k < 3; k++) begin : g_pack
    assign vin[k].x = vx[k];
    assign vin[k].y = vy[k];
    assign vin[k].z = vz[k];
    assign vin[k].i = vi[k];
  end

  tri_vsort u_sort (.vin(vin), .vout(vsrt));

  ctx_t                   r_q, r_d;
  logic signed [ACCW-1:0] num, quo;
  logic [DW-1:0]          den;
  logic                   fin, eol, long_left;
  logic [XW-1:0]          lxi, sxi;
  vtx_t                   sp, sq;

  tri_sdiv #(.NW(ACCW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rs_n), .go(r_q.go), .num(num), .den(den), .fin(fin), .quo(quo)
  );

  always_comb begin
    r_d       = r_q;
    r_d.go    = 1'b0;
    eol       = 1'b0;
    lxi       = r_q.lac[0][FRAC +: XW];
    sxi       = r_q.sac[0][FRAC +: XW];
    long_left = (lxi <= sxi);
    sp        = r_q.seg ? r_q.b : r_q.a;
    sq        = r_q.seg ? r_q.c : r_q.b;
    num       = '0;
    den       = '0;
    unique case (r_q.st)
      ST_LDIV: begin num = fxv(r_q.c, int'(r_q.dq)) - fxv(r_q.a, int'(r_q.dq));
                     den = DW'(r_q.c.y - r_q.a.y); end
      ST_SDIV: begin num = fxv(sq, int'(r_q.dq)) - fxv(sp, int'(r_q.dq));
                     den = DW'(sq.y - sp.y); end
      ST_PDIV: begin num = r_q.er[r_q.dq[0]] - r_q.el[r_q.dq[0]];
                     den = DW'(r_q.xr - r_q.xl); end
      default: ;
    endcase

    unique case (r_q.st)
      ST_IDLE: if (start) begin
        r_d.a = vsrt[0]; r_d.b = vsrt[1]; r_d.c = vsrt[2];
        r_d.seg = 1'b0; r_d.dq = '0;
        for (int k = 0; k < 3; k++) r_d.lac[k] = fxv(vsrt[0], k);
        if (vsrt[2].y == vsrt[0].y) r_d.st = ST_FIN;
        else begin r_d.st = ST_LDIV; r_d.go = 1'b1; end
      end
      ST_LDIV: if (fin) begin
        r_d.lst[r_q.dq] = quo;
        if (r_q.dq == 2'd2) r_d.st = ST_SEG;
        else begin r_d.dq = r_q.dq + 1'b1; r_d.go = 1'b1; end
      end
      ST_SEG: begin
        if (sq.y == sp.y) begin
          if (r_q.seg) r_d.st = ST_FIN;
          else         r_d.seg = 1'b1;
        end else begin
          r_d.y = sp.y; r_d.yend = sq.y; r_d.dq = '0; r_d.go = 1'b1; r_d.st = ST_SDIV;
          for (int k = 0; k < 3; k++) r_d.sac[k] = fxv(sp, k);
        end
      end
      ST_SDIV: if (fin) begin
        r_d.sst[r_q.dq] = quo;
        if (r_q.dq == 2'd2) r_d.st = ST_LINE;
        else begin r_d.dq = r_q.dq + 1'b1; r_d.go = 1'b1; end
      end
      ST_LINE: begin
        if (long_left) begin
          r_d.xl = lxi; r_d.xr = sxi;
          r_d.el = {r_q.lac[2], r_q.lac[1]}; r_d.er = {r_q.sac[2], r_q.sac[1]};
        end else begin
          r_d.xl = sxi; r_d.xr = lxi;
          r_d.el = {r_q.sac[2], r_q.sac[1]}; r_d.er = {r_q.lac[2], r_q.lac[1]};
        end
        r_d.ph = PH_L;
        if (r_d.xr != r_d.xl) begin r_d.st = ST_PDIV; r_d.dq = '0; r_d.go = 1'b1; end
        else r_d.st = ST_EMIT;
      end
      ST_PDIV: if (fin) begin
        r_d.pst[r_q.dq[0]] = quo;
        if (r_q.dq[0]) r_d.st = ST_EMIT;
        else begin r_d.dq = 2'd1; r_d.go = 1'b1; end
      end
      ST_EMIT: if (pix_ready) begin
        unique case (r_q.ph)
          PH_L: if (r_q.xr == r_q.xl) eol = 1'b1; else r_d.ph = PH_R;
          PH_R: if (r_q.xr == r_q.xl + XW'(1)) eol = 1'b1;
                else begin
                  r_d.ph = PH_IN; r_d.px = r_q.xl + XW'(1);
                  for (int k = 0; k < 2; k++) r_d.pac[k] = r_q.el[k] + r_q.pst[k];
                end
          default: if (r_q.px == r_q.xr - XW'(1)) eol = 1'b1;
                else begin
                  r_d.px = r_q.px + XW'(1);
                  for (int k = 0; k < 2; k++) r_d.pac[k] = r_q.pac[k] + r_q.pst[k];
                end
        endcase
      end
      ST_FIN:  r_d.st = ST_IDLE;
      default: r_d.st = ST_IDLE;
    endcase

    if (eol) begin
      for (int k = 0; k < 3; k++) begin
        r_d.lac[k] = r_q.lac[k] + r_q.lst[k];
        r_d.sac[k] = r_q.sac[k] + r_q.sst[k];
      end
      r_d.y = r_q.y + YW'(1);
      if ((r_q.y + YW'(1)) != r_q.yend) r_d.st = ST_LINE;
      else if (r_q.seg)                 r_d.st = ST_FIN;
      else begin r_d.seg = 1'b1; r_d.st = ST_SEG; end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) r_q <= '0;
    else       r_q <= r_d;
  end

  always_comb begin
    busy      = (r_q.st != ST_IDLE);
    done      = (r_q.st == ST_FIN);
    pix_valid = (r_q.st == ST_EMIT);
    pix_y     = r_q.y;
    unique case (r_q.ph)
      PH_L:    begin pix_x = r_q.xl; pix_z = r_q.el[0][FRAC +: ZW]; pix_i = r_q.el[1][FRAC +: IW]; end
      PH_R:    begin pix_x = r_q.xr; pix_z = r_q.er[0][FRAC +: ZW]; pix_i = r_q.er[1][FRAC +: IW]; end
      default: begin pix_x = r_q.px; pix_z = r_q.pac[0][FRAC +: ZW]; pix_i = r_q.pac[1][FRAC +: IW]; end
    endcase
  end

  // R1
  sorted_chk: assert property (@(posedge clk) disable iff (!rs_n)
    busy |-> (r_q.a.y <= r_q.b.y) && (r_q.b.y <= r_q.c.y));
  // R2
  row_range_chk: assert property (@(posedge clk) disable iff (!rs_n)
    pix_valid |-> (pix_y >= r_q.a.y) && (pix_y < r_q.c.y));
  // R4
  inner_span_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (pix_valid && r_q.ph == PH_IN) |-> (pix_x > r_q.xl) && (pix_x < r_q.xr));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (pix_valid && !pix_ready) |=> pix_valid && $stable(pix_x) && $stable(pix_y)
                                 && $stable(pix_z) && $stable(pix_i));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rs_n)
    done |=> !done && !busy);
  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (busy && start) |=> $stable(r_q.a) && $stable(r_q.c));
endmodule

// File: tb/scan_tri_raster_tb_top.sv
module scan_tri_raster_tb_top;
  import tri_pkg::*;

  typedef struct { int x; int y; int z; int i; } pix_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pix_ready = 1'b0;
  logic [2:0][XW-1:0] vx = '0;
  logic [2:0][YW-1:0] vy = '0;
  logic [2:0][ZW-1:0] vz = '0;
  logic [2:0][IW-1:0] vi = '0;
  logic busy, pix_valid, done;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;
  logic [ZW-1:0] pix_z;
  logic [IW-1:0] pix_i;

  always #4 clk = ~clk;

  scan_tri_raster dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vx(vx), .vy(vy), .vz(vz), .vi(vi),
    .busy(busy), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y), .pix_z(pix_z), .pix_i(pix_i), .done(done)
  );

  int nvec = 0, nfail = 0, done_cnt = 0, ready_pct = 100;
  bit mon_en = 1'b0;
  string cur_tag = "R2";
  pix_t expq[$];
  int tx[3], ty[3], tz[3], ti[3];
  longint F = longint'(1) << FRAC;

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    nfail++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic push_px(input longint x, input longint y, input longint z, input longint i);
    pix_t p;
    p.x = int'(x); p.y = int'(y); p.z = int'(z >>> FRAC); p.i = int'(i >>> FRAC);
    expq.push_back(p);
  endtask

  // behavioural reference built straight from the requirements
  task automatic build_ref();
    int o[3];
    longint v[3][3], lst[3], sst[3], L[3], S[3], el[3], er[3], ps[3];
    longint xl, xr;
    int p, q, t;
    o = '{0, 1, 2};
    for (int pass = 0; pass < 2; pass++)
      for (int j = 0; j < 2; j++)
        if (ty[o[j+1]] < ty[o[j]]) begin t = o[j]; o[j] = o[j+1]; o[j+1] = t; end
    for (int j = 0; j < 3; j++) begin
      v[j][0] = tx[o[j]]; v[j][1] = tz[o[j]]; v[j][2] = ti[o[j]];
    end
    if (ty[o[2]] == ty[o[0]]) return;
    for (int k = 0; k < 3; k++) lst[k] = ((v[2][k] - v[0][k]) * F) / (ty[o[2]] - ty[o[0]]);
    for (int sg = 0; sg < 2; sg++) begin
      p = sg; q = sg + 1;
      if (ty[o[q]] == ty[o[p]]) continue;
      for (int k = 0; k < 3; k++) sst[k] = ((v[q][k] - v[p][k]) * F) / (ty[o[q]] - ty[o[p]]);
      for (int y = ty[o[p]]; y < ty[o[q]]; y++) begin
        for (int k = 0; k < 3; k++) begin
          L[k] = v[0][k] * F + longint'(y - ty[o[0]]) * lst[k];
          S[k] = v[p][k] * F + longint'(y - ty[o[p]]) * sst[k];
        end
        if ((L[0] >>> FRAC) <= (S[0] >>> FRAC)) begin el = L; er = S; end
        else begin el = S; er = L; end
        xl = el[0] >>> FRAC; xr = er[0] >>> FRAC;
        push_px(xl, y, el[1], el[2]);
        if (xr != xl) push_px(xr, y, er[1], er[2]);
        if (xr > xl) begin
          for (int k = 1; k < 3; k++) ps[k] = (er[k] - el[k]) / (xr - xl);
          for (longint k = 1; k < xr - xl; k++)
            push_px(xl + k, y, el[1] + k * ps[1], el[2] + k * ps[2]);
        end
      end
    end
  endtask

  // monitor: drives ready and checks every accepted fragment
  bit   hold_v = 1'b0;
  pix_t hold_p;
  always @(negedge clk) begin
    bit rdy;
    pix_t e;
    if (mon_en) begin
      if (hold_v) begin
        nvec++;
        if (!pix_valid || pix_x != hold_p.x[XW-1:0] || pix_y != hold_p.y[YW-1:0] ||
            pix_z != hold_p.z[ZW-1:0] || pix_i != hold_p.i[IW-1:0])
          fail_line("R6", "stalled fragment x", int'(pix_x), hold_p.x);
      end
      rdy = ($urandom_range(0, 99) < ready_pct);
      pix_ready = rdy;
      hold_v = pix_valid && !rdy;
      hold_p.x = int'(pix_x); hold_p.y = int'(pix_y); hold_p.z = int'(pix_z); hold_p.i = int'(pix_i);
      if (pix_valid && rdy) begin
        nvec++;
        if (expq.size() == 0) fail_line(cur_tag, "unexpected fragment x", int'(pix_x), -1);
        else begin
          e = expq.pop_front();
          if (int'(pix_x) != e.x) fail_line(cur_tag, "x", int'(pix_x), e.x);
          else if (int'(pix_y) != e.y) fail_line(cur_tag, "y", int'(pix_y), e.y);
          else if (int'(pix_z) != e.z) fail_line("R5", "z", int'(pix_z), e.z);
          else if (int'(pix_i) != e.i) fail_line("R5", "intensity", int'(pix_i), e.i);
        end
      end
      if (done) begin
        nvec++;
        if (expq.size() != 0) fail_line("R7", "fragments left at done", expq.size(), 0);
        done_cnt++;
      end
    end
  end

  task automatic drive_tri();
    for (int k = 0; k < 3; k++) begin
      vx[k] = XW'(tx[k]); vy[k] = YW'(ty[k]); vz[k] = ZW'(tz[k]); vi[k] = IW'(ti[k]);
    end
  endtask

  task automatic run_tri(input string tag, input bit inject);
    int d0, guard;
    cur_tag = tag;
    build_ref();
    d0 = done_cnt;
    @(negedge clk); drive_tri(); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (inject) begin
      // R8: a second request while busy must change nothing
      repeat (4) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        vx[k] = XW'(k * 50 + 3); vy[k] = YW'(k * 9); vz[k] = ZW'(7); vi[k] = IW'(200);
      end
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 40000) begin @(negedge clk); guard++; end
    nvec++;
    if (done_cnt == d0) fail_line(tag, "done never seen", 0, 1);
    @(negedge clk);
    nvec++;
    if (busy !== 1'b0) fail_line("R7", "busy after done", int'(busy), 0);
  endtask

  task automatic set_tri(input int x0, y0, z0, i0, x1, y1, z1, i1, x2, y2, z2, i2);
    tx = '{x0, x1, x2}; ty = '{y0, y1, y2}; tz = '{z0, z1, z2}; ti = '{i0, i1, i2};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nvec++;
    if (busy !== 1'b0 || pix_valid !== 1'b0 || done !== 1'b0)
      fail_line("R9", "outputs in reset", int'({busy, pix_valid, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    nvec++;
    if (busy !== 1'b0 || pix_valid !== 1'b0 || done !== 1'b0)
      fail_line("R9", "outputs after reset", int'({busy, pix_valid, done}), 0);
    mon_en = 1'b1;

    set_tri(10, 5, 300, 20,  30, 20, 900, 120,  4, 28, 3000, 250); run_tri("R2", 1'b0);
    ready_pct = 60;
    set_tri(20, 2, 100, 10,  5, 12, 800, 90,  35, 12, 1500, 200); run_tri("R2", 1'b0);
    set_tri(3, 4, 4000, 255,  25, 4, 2000, 100,  14, 18, 50, 0);  run_tri("R3", 1'b0);
    set_tri(25, 9, 500, 30,  3, 9, 3500, 220,  14, 22, 1200, 80); run_tri("R1", 1'b0);
    set_tri(3, 9, 3500, 220,  25, 9, 500, 30,  14, 22, 1200, 80); run_tri("R1", 1'b0);
    set_tri(30, 0, 10, 5,  2, 12, 2000, 40,  34, 26, 4095, 255);  run_tri("R4", 1'b0);
    set_tri(10, 0, 600, 60,  10, 15, 610, 61,  11, 30, 620, 62);  run_tri("R4", 1'b0);
    set_tri(7, 7, 1, 1,  40, 7, 2, 2,  90, 7, 3, 3);              run_tri("R1", 1'b0);
    ready_pct = 30;
    set_tri(0, 100, 4095, 255,  255, 103, 0, 0,  128, 106, 2000, 128); run_tri("R5", 1'b0);
    set_tri(12, 3, 900, 40,  28, 14, 100, 200,  6, 20, 2500, 10); run_tri("R8", 1'b1);
    for (int n = 0; n < 12; n++) begin
      ready_pct = (n % 3 == 0) ? 100 : ((n % 3 == 1) ? 55 : 25);
      for (int k = 0; k < 3; k++) begin
        tx[k] = $urandom_range(0, 40); ty[k] = $urandom_range(0, 40);
        tz[k] = $urandom_range(0, 4095); ti[k] = $urandom_range(0, 255);
      end
      run_tri("R3", 1'b0);
    end
    mon_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule